// File: doc/BRIEF.md
# Generation-2 Stall Recovery Sequencer

This block is started by a link supervisor when a link-up poll finds the link only partly trained. It decides whether a speed move to generation 2 has stalled, and if it has, it kicks the PHY receiver back into lock. It first reads the PHY's receiver status register. If the receiver reports valid data, or the 6-bit LTSSM state taken from a debug word is anything other than the recovery receiver-lock code, it ends without touching anything. Otherwise it applies a timed receiver reset through read-modify-write accesses to the PHY's receive-override register. It sets the data-enable and PLL-enable override bits, holds them for a programmable number of cycles, then clears them again.

Every PHY access goes out through a simple request port with address, write data, a direction flag and a valid. The port is answered by done, read data and an error flag. Only one request is outstanding at a time. The port suits the usual indirect handshake engine placed in front of a PHY control bus. An error on any access aborts the sequence and raises a fault flag. A completed recovery gives a one-cycle pulse, so the caller can resume its link polling. The hold count is set at build time; about 2 ms at the system clock matches the PHY's lock time, which is far shorter than the training timeout.

Top module: `gen2_stall_recover`

## Requirements
- R1: After reset, `phy_req_valid`, `busy`, `fault` and `recovered` are all 0.
- R2: A `start` pulse while idle raises `busy` one cycle later. It also issues a read (`phy_req_write`=0) of the receiver status address `RXV_ADDR` (default 0x100D) as the first request.
- R3: A request stays valid, with address, direction and write data unchanged, until the cycle in which `phy_done` is seen. Only one request is outstanding at a time.
- R4: If bit `RXV_BIT` (default 0) of the status read data is 1, the sequence ends after that single access, with no `recovered` pulse and no fault.
- R5: If the receiver bit is 0 but `ltssm_state` (bits 5:0) at completion of that read differs from `STUCK_CODE` (default 0x0D), the sequence ends after that single access with no further action.
- R6: Otherwise the block reads the override address `OVR_ADDR` (default 0x1005). It then writes back the value read with bits `DATA_EN_BIT` (5) and `PLL_EN_BIT` (3) set and all other bits unchanged.
- R7: The request for the clearing write starts at least `HOLD_CYCLES` cycles after the setting write completes.
- R8: After the hold the block reads `OVR_ADDR` again. It writes back that value with bits 5 and 3 cleared and all other bits unchanged.
- R9: Completion of the clearing write produces exactly one one-cycle `recovered` pulse, and `busy` is 0 afterwards.
- R10: `phy_err` on any completed access ends the sequence with no further request and sets `fault`. `fault` stays 1 until the next accepted `start` clears it.
- R11: `start` pulses while `busy` is 1 are ignored; the running sequence issues the same accesses and the same single `recovered` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one check-and-recover pass (ignored while busy) |
| ltssm_state | input | 6 | LTSSM state field from the controller debug word |
| phy_req_valid | output | 1 | PHY request pending |
| phy_req_write | output | 1 | 1 = write, 0 = read |
| phy_req_addr | output | 16 | PHY register address |
| phy_req_wdata | output | 16 | PHY write data |
| phy_done | input | 1 | Request completed this cycle |
| phy_rdata | input | 16 | Read data, valid with `phy_done` |
| phy_err | input | 1 | Access failed, valid with `phy_done` |
| busy | output | 1 | Sequence in progress |
| fault | output | 1 | Last sequence aborted on a PHY error |
| recovered | output | 1 | One-cycle pulse when the receiver reset completes |

## Verification
The hardest condition to reach is a PHY error on a late access, such as the setting write or the final clearing write. An error there must leave the override register in a known state and still stop the block. The bench's PHY responder holds a model of both registers with a per-run latency. It takes an injection index that fails exactly the Nth access of a pass, so each abort point is reached on purpose. The hold window is measured from the responder's own cycle log of request start and completion times. A second start pulse is also fired while the block sits in the hold.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_RX,
    S_RD_OVR_SET,
    S_WR_OVR_SET,
    S_HOLD,
    S_RD_OVR_CLR,
    S_WR_OVR_CLR
  } seq_state_t;
endpackage

// File: rtl/gsr_req_port.sv
module gsr_req_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              issue_write,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_wdata,
  input  logic              phy_done,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              accepted
);
  assign accepted = req_valid && phy_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_write <= issue_write;
      req_addr  <= issue_addr;
      req_wdata <= issue_wdata;
    end else if (accepted) begin
      req_valid <= 1'b0;
    end
  end

  // R3: a pending request is held unchanged until completion
  p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !phy_done) |=> (req_valid && $stable(req_addr) &&
                                  $stable(req_write) && $stable(req_wdata)));

  // R3: a new request is only launched when none is outstanding
  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
    issue |-> (!req_valid || phy_done));
endmodule

// File: rtl/gsr_hold_timer.sv
module gsr_hold_timer #(
  parameter int HOLD_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CW'(HOLD_CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R7: the down-counter never exceeds its load value while running
  p_timer_range_r7: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= CW'(HOLD_CYCLES - 1)));
endmodule

// File: rtl/gen2_stall_recover.sv
module gen2_stall_recover
  import gsr_pkg::*;
#(
  parameter int                 ADDR_W      = 16,
  parameter int                 DATA_W      = 16,
  parameter int                 STATE_W     = 6,
  parameter logic [ADDR_W-1:0]  RXV_ADDR    = 16'h100D,
  parameter logic [ADDR_W-1:0]  OVR_ADDR    = 16'h1005,
  parameter int                 RXV_BIT     = 0,
  parameter int                 DATA_EN_BIT = 5,
  parameter int                 PLL_EN_BIT  = 3,
  parameter logic [STATE_W-1:0] STUCK_CODE  = 6'h0D,
  parameter int                 HOLD_CYCLES = 200000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [STATE_W-1:0] ltssm_state,
  output logic               phy_req_valid,
  output logic               phy_req_write,
  output logic [ADDR_W-1:0]  phy_req_addr,
  output logic [DATA_W-1:0]  phy_req_wdata,
  input  logic               phy_done,
  input  logic [DATA_W-1:0]  phy_rdata,
  input  logic               phy_err,
  output logic               busy,
  output logic               fault,
  output logic               recovered
);
  localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] OVR_MASK = (ONE << DATA_EN_BIT) | (ONE << PLL_EN_BIT);
  localparam int                GW       = $clog2(HOLD_CYCLES + 1) + 1;

  seq_state_t        state, state_nx;
  logic              issue, issue_write;
  logic [ADDR_W-1:0] issue_addr;
  logic [DATA_W-1:0] issue_wdata;
  logic              accepted;
  logic              tmr_load, tmr_expired;
  logic              set_fault, set_rec;

  gsr_req_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .issue(issue), .issue_write(issue_write),
    .issue_addr(issue_addr), .issue_wdata(issue_wdata),
    .phy_done(phy_done),
    .req_valid(phy_req_valid), .req_write(phy_req_write),
    .req_addr(phy_req_addr), .req_wdata(phy_req_wdata),
    .accepted(accepted)
  );

  gsr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst(rst), .load(tmr_load), .expired(tmr_expired)
  );

  always_comb begin
    state_nx    = state;
    issue       = 1'b0;
    issue_write = 1'b0;
    issue_addr  = OVR_ADDR;
    issue_wdata = '0;
    tmr_load    = 1'b0;
    set_fault   = 1'b0;
    set_rec     = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        issue      = 1'b1;
        issue_addr = RXV_ADDR;
        state_nx   = S_RD_RX;
      end
      S_RD_RX: if (accepted) begin
        if (phy_err) begin
          set_fault = 1'b1;
          state_nx  = S_IDLE;
        end else if (phy_rdata[RXV_BIT] || (ltssm_state != STUCK_CODE)) begin
          state_nx = S_IDLE;
        end else begin
          issue    = 1'b1;
          state_nx = S_RD_OVR_SET;
        end
      end
      S_RD_OVR_SET: if (accepted) begin
        if (phy_err) begin
          set_fault = 1'b1;
          state_nx  = S_IDLE;
        end else begin
          issue       = 1'b1;
          issue_write = 1'b1;
          issue_wdata = phy_rdata | OVR_MASK;
          state_nx    = S_WR_OVR_SET;
        end
      end
      S_WR_OVR_SET: if (accepted) begin
        if (phy_err) begin
          set_fault = 1'b1;
          state_nx  = S_IDLE;
        end else begin
          tmr_load = 1'b1;
          state_nx = S_HOLD;
        end
      end
      S_HOLD: if (tmr_expired) begin
        issue    = 1'b1;
        state_nx = S_RD_OVR_CLR;
      end
      S_RD_OVR_CLR: if (accepted) begin
        if (phy_err) begin
          set_fault = 1'b1;
          state_nx  = S_IDLE;
        end else begin
          issue       = 1'b1;
          issue_write = 1'b1;
          issue_wdata = phy_rdata & ~OVR_MASK;
          state_nx    = S_WR_OVR_CLR;
        end
      end
      S_WR_OVR_CLR: if (accepted) begin
        if (phy_err) set_fault = 1'b1;
        else         set_rec   = 1'b1;
        state_nx = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fault     <= 1'b0;
      recovered <= 1'b0;
    end else begin
      state     <= state_nx;
      recovered <= set_rec;
      if (set_fault)                    fault <= 1'b1;
      else if (state == S_IDLE && start) fault <= 1'b0;
    end
  end

  assign busy = (state != S_IDLE);

  // Independent cycle count since the setting write completed (R7 check)
  logic [GW-1:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (rst)                                             gap_cnt <= '0;
    else if (state == S_WR_OVR_SET && accepted && !phy_err) gap_cnt <= '0;
    else if (gap_cnt != '1)                              gap_cnt <= gap_cnt + 1'b1;
  end

  // R7: leaving the hold only after the full hold window
  p_hold_window_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && issue) |-> (gap_cnt >= GW'(HOLD_CYCLES - 1)));

  // R2: first request of a pass reads the receiver status register
  p_first_read_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(phy_req_valid) && state == S_RD_RX) |-> (!phy_req_write && phy_req_addr == RXV_ADDR));

  // R6: setting write carries both override bits
  p_set_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (phy_req_valid && state == S_WR_OVR_SET) |-> ((phy_req_wdata & OVR_MASK) == OVR_MASK));

  // R8: clearing write carries neither override bit
  p_clr_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (phy_req_valid && state == S_WR_OVR_CLR) |-> ((phy_req_wdata & OVR_MASK) == '0));

  // R4 R5: nothing is pending while idle
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !phy_req_valid);

  // R9: recovered is a single-cycle pulse ending in idle
  p_rec_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    recovered |-> (!busy ##1 !recovered));

  // R10: a raised fault leaves no request in flight
  p_fault_stop_r10: assert property (@(posedge clk) disable iff (rst)
    fault |-> !phy_req_valid);
endmodule

// File: tb/test_gen2_stall_recover.sv
module test_gen2_stall_recover;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 40;

  typedef struct packed {
    logic [15:0] rx;
    logic [15:0] ovr;
    logic [5:0]  st;
    logic [2:0]  err_at;
    logic [1:0]  lat;
    logic [2:0]  nacc;
    logic        rec;
    logic        flt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{16'h0001, 16'h0000, 6'h0D, 3'd0, 2'd1, 3'd1, 1'b0, 1'b0},  // R4
    '{16'h0000, 16'h0000, 6'h11, 3'd0, 2'd2, 3'd1, 1'b0, 1'b0},  // R5
    '{16'hFFFE, 16'h1234, 6'h0D, 3'd0, 2'd1, 3'd5, 1'b1, 1'b0},  // R6 R8 R9
    '{16'h8000, 16'hFFFF, 6'h0D, 3'd0, 2'd3, 3'd5, 1'b1, 1'b0},
    '{16'h0000, 16'h0000, 6'h0D, 3'd1, 2'd1, 3'd1, 1'b0, 1'b1},  // R10
    '{16'h0000, 16'h0000, 6'h0D, 3'd3, 2'd2, 3'd3, 1'b0, 1'b1},  // R10
    '{16'h0000, 16'h00F0, 6'h2D, 3'd0, 2'd1, 3'd1, 1'b0, 1'b0},  // R5
    '{16'h0000, 16'h0028, 6'h0D, 3'd5, 2'd1, 3'd5, 1'b0, 1'b1}   // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  ltssm = '0;
  logic        phy_done = 1'b0;
  logic [15:0] phy_rdata = '0;
  logic        phy_err = 1'b0;
  logic        req_valid, req_write, busy, fault, recovered;
  logic [15:0] req_addr, req_wdata;

  gen2_stall_recover #(.HOLD_CYCLES(HOLD)) i_gen2_stall_recover (
    .clk(clk), .rst(rst), .start(start), .ltssm_state(ltssm),
    .phy_req_valid(req_valid), .phy_req_write(req_write),
    .phy_req_addr(req_addr), .phy_req_wdata(req_wdata),
    .phy_done(phy_done), .phy_rdata(phy_rdata), .phy_err(phy_err),
    .busy(busy), .fault(fault), .recovered(recovered)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Stimulus-side model settings (written only by the test process)
  logic [15:0] m_rx = '0, m_ovr = '0;
  int          err_at = 0, lat = 1, run_base = 0;

  // Responder state (written only by the responder)
  int          acc_n = 0, wcnt = 0, last_wr = -1, stable_bad = 0, rec_n = 0;
  logic [15:0] wr_val = '0;
  logic [15:0] lg_addr [64];
  logic        lg_wr   [64];
  logic [15:0] lg_wd   [64];
  int          lg_st   [64];
  int          lg_dn   [64];

  always @(negedge clk) begin
    if (recovered) rec_n++;
    if (rst) begin
      phy_done = 1'b0; phy_err = 1'b0; wcnt = 0;
    end else if (phy_done) begin
      phy_done = 1'b0; phy_err = 1'b0; wcnt = 0;
    end else if (req_valid) begin
      if (wcnt == 0) begin
        lg_addr[acc_n & 63] = req_addr;
        lg_wr[acc_n & 63]   = req_write;
        lg_wd[acc_n & 63]   = req_wdata;
        lg_st[acc_n & 63]   = cyc;
      end else if (lg_addr[acc_n & 63] != req_addr || lg_wr[acc_n & 63] != req_write ||
                   lg_wd[acc_n & 63] != req_wdata) begin
        stable_bad++;
      end
      wcnt++;
      if (wcnt >= lat) begin
        phy_done = 1'b1;
        lg_dn[acc_n & 63] = cyc;
        if (acc_n - run_base + 1 == err_at) begin
          phy_err = 1'b1;
        end else if (req_write && req_addr == 16'h1005) begin
          wr_val  = req_wdata;
          last_wr = acc_n;
        end
        if (req_addr == 16'h100D)      phy_rdata = m_rx;
        else if (req_addr == 16'h1005) phy_rdata = (last_wr >= run_base) ? wr_val : m_ovr;
        else                           phy_rdata = 16'hDEAD;
        acc_n++;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit mid_start);
    int rec0, sb0, n, w1, w2;
    m_rx = v.rx; m_ovr = v.ovr; ltssm = v.st; err_at = int'(v.err_at); lat = int'(v.lat);
    @(negedge clk);
    run_base = acc_n; rec0 = rec_n; sb0 = stable_bad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(fault == 1'b0, "R10 fault cleared by start", fault, 0);
    chk(req_valid && !req_write && req_addr == 16'h100D, "R2 first request", req_addr, 16'h100D);
    if (mid_start) begin
      repeat (14) @(negedge clk);
      chk(busy == 1'b1, "R11 still busy before extra start", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 600 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    n = acc_n - run_base;
    chk(busy == 1'b0, "R9 busy low at end", busy, 0);
    chk(n == int'(v.nacc), "R4 R5 R10 R11 access count", n, v.nacc);
    chk(rec_n - rec0 == int'(v.rec), "R9 R11 recovered pulses", rec_n - rec0, v.rec);
    chk(fault == v.flt, "R10 fault", fault, v.flt);
    chk(stable_bad == sb0, "R3 request stability", stable_bad - sb0, 0);
    chk(req_valid == 1'b0, "R4 R10 no request left", req_valid, 0);
    w1 = v.ovr | 16'h0028;
    w2 = w1 & ~16'h0028;
    if (n >= 2)
      chk(!lg_wr[(run_base+1) & 63] && lg_addr[(run_base+1) & 63] == 16'h1005,
          "R6 override read", lg_addr[(run_base+1) & 63], 16'h1005);
    if (n >= 3)
      chk(lg_wr[(run_base+2) & 63] && lg_wd[(run_base+2) & 63] == 16'(w1),
          "R6 setting write", lg_wd[(run_base+2) & 63], w1);
    if (n >= 5) begin
      chk(!lg_wr[(run_base+3) & 63] && lg_addr[(run_base+3) & 63] == 16'h1005,
          "R8 second override read", lg_addr[(run_base+3) & 63], 16'h1005);
      chk(lg_wr[(run_base+4) & 63] && lg_wd[(run_base+4) & 63] == 16'(w2),
          "R8 clearing write", lg_wd[(run_base+4) & 63], w2);
      chk(lg_st[(run_base+4) & 63] - lg_dn[(run_base+2) & 63] >= HOLD,
          "R7 write separation", lg_st[(run_base+4) & 63] - lg_dn[(run_base+2) & 63], HOLD);
    end
  endtask

  task automatic all_tests();
    vec_t d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!req_valid && !busy && !fault && !recovered, "R1 reset outputs",
        {req_valid, busy, fault, recovered}, 0);
    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);
    // R11 extra start during hold of a stalled pass
    d = '{16'h0000, 16'h0A5A, 6'h0D, 3'd0, 2'd1, 3'd5, 1'b1, 1'b0};
    run(d, 1'b1);
    // R10 fault from clearing write, then a clean pass clears it
    d = '{16'h0000, 16'h0001, 6'h0D, 3'd5, 2'd2, 3'd5, 1'b0, 1'b1};
    run(d, 1'b0);
    d = '{16'h0001, 16'h0000, 6'h0D, 3'd0, 2'd1, 3'd1, 1'b0, 1'b0};
    run(d, 1'b0);
    // R1 reset in the middle of a hold returns everything to idle
    m_rx = 16'h0000; ltssm = 6'h0D; err_at = 0; lat = 1;
    @(negedge clk); run_base = acc_n; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_valid && !busy && !fault && !recovered, "R1 reset mid-pass",
        {req_valid, busy, fault, recovered}, 0);
  endtask

  initial begin
    fork
      all_tests();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule